// File: doc/BRIEF.md
# Multicore Interrupt Distributor

This block collects interrupt requests and hands them to as many as four CPUs. There are three kinds of source. The first is software interrupts, which a write on the configuration port raises. The second is two private lines per CPU: a timer and a watchdog. The third is a parameterised set of shared hardware lines. Each CPU keeps its own bank of enable bits and 4-bit priorities. Each CPU also keeps its own record of which interrupts it has taken and not yet completed. The shared lines have a routing mask that chooses which CPUs see them.

Each CPU has three signals. A request output rises whenever some interrupt would win. An acknowledge strobe returns the winning ID and marks that interrupt as taken. An end-of-interrupt strobe with an ID releases a taken interrupt. An interrupt that is taken can be overtaken by a strictly more urgent one, so several interrupts can be taken on one CPU at a time. The CPU's running priority is always the most urgent of its taken interrupts. A legacy fast-interrupt input per CPU passes straight through to an output.

Top module: `midist_top`

## Requirements
- R1: After reset, the request outputs are low while no source is raised. Every acknowledge output reads 1023. All enables, priorities, routes and taken states are clear.
- R2: The ID map is as follows. IDs 0..15 are software interrupts. ID 29 is the CPU's `timer_irq` bit and ID 30 is its `wdog_irq` bit. ID 32+k is `shared_in[k]`.
- R3: Enable register (cfg_addr 0). It takes the ID from cfg_wdata[9:0] and the value from cfg_wdata[16]. The write applies only to the bank of the CPU given by `cfg_cpu`. A CPU never requests or acknowledges an interrupt that is disabled in its bank.
- R4: Priority register (cfg_addr 1). It takes the ID from cfg_wdata[9:0] and the priority from cfg_wdata[19:16]. The priority is banked per CPU, so the receiving CPU's bank sets the priority of a software interrupt. A lower value is more urgent, and on a tie the lower ID wins.
- R5: Route register (cfg_addr 2). It takes the ID from cfg_wdata[9:0] and applies only to IDs 32 and up. Bit c of cfg_wdata[16+:NCPU] lets CPU c see that shared line. A CPU whose bit is clear never sees the line.
- R6: Software interrupt write (cfg_addr 3). The ID comes from cfg_wdata[3:0] and the mode from cfg_wdata[17:16]. Mode 0 targets the CPUs listed in cfg_wdata[24+:NCPU]. Mode 1 targets every CPU except `cfg_cpu`. Mode 2 targets `cfg_cpu` only. Mode 3 targets no CPU. The targets see the interrupt as pending from the cycle after the write.
- R7: `cpu_irq[c]` is combinational. It is high exactly when some interrupt is raised, not taken on CPU c, enabled for CPU c, and of a priority strictly below CPU c's running priority. The running priority is 16 when CPU c has nothing taken.
- R8: An acknowledge loads `cpu_ack_id` on the clock edge that samples it, and the value holds until the next acknowledge. It returns the winning ID and marks that interrupt taken. If nothing qualifies it returns 1023 and changes no state.
- R9: While an interrupt is taken, only a strictly more urgent one can be acknowledged on that CPU. The running priority is the most urgent priority among the taken interrupts.
- R10: End of interrupt releases the given ID on that CPU and restores the previous running priority. A hardware line that is still high becomes pending again. An ID that is not taken, or that is out of range, has no effect.
- R11: `fiq_out` equals `fiq_in` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cpu | input | CW | CPU that performs the write (selects the bank or the sender) |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Write data |
| shared_in | input | NSHARED | Shared level-sensitive interrupt lines |
| timer_irq | input | NCPU | Private timer line per CPU |
| wdog_irq | input | NCPU | Private watchdog line per CPU |
| fiq_in | input | NCPU | Legacy fast-interrupt inputs |
| cpu_ack | input | NCPU | Acknowledge strobe per CPU |
| cpu_eoi | input | NCPU | End-of-interrupt strobe per CPU |
| cpu_eoi_id | input | NCPU*10 | End-of-interrupt ID per CPU |
| cpu_irq | output | NCPU | Request per CPU |
| cpu_ack_id | output | NCPU*10 | Last acknowledged ID per CPU |
| fiq_out | output | NCPU | Fast-interrupt pass-through |

## Verification
The bench builds the block with NCPU=4 and NSHARED=8, which gives 40 IDs per CPU. With four CPUs, every software-interrupt mode produces a target set that differs from the others: all but self, self only, a sparse list, and nobody. It also allows a route mask that covers one CPU, some CPUs or every CPU. Eight shared lines keep the per-cycle model comparison cheap, while still crossing the boundary at ID 32 and reaching the timer and watchdog IDs.

// File: rtl/midist_pkg.sv
package midist_pkg;
  localparam int ID_W        = 10;
  localparam int PRIO_W      = 4;
  localparam int NUM_SOFT    = 16;
  localparam int ID_TIMER    = 29;
  localparam int ID_WDOG     = 30;
  localparam int SHARED_BASE = 32;
  localparam logic [ID_W-1:0] ID_NONE = 10'd1023;

  typedef enum logic [1:0] {
    REG_ENABLE = 2'd0,
    REG_PRIO   = 2'd1,
    REG_ROUTE  = 2'd2,
    REG_SOFT   = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SOFT_LIST   = 2'd0,
    SOFT_OTHERS = 2'd1,
    SOFT_SELF   = 2'd2,
    SOFT_NONE   = 2'd3
  } soft_mode_e;
endpackage

// File: rtl/midist_route.sv
module midist_route
  import midist_pkg::*;
#(
  parameter int NCPU    = 4,
  parameter int NSHARED = 8,
  localparam int CW     = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int SW     = (NSHARED > 1) ? $clog2(NSHARED) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [1:0]                  cfg_addr,
  input  logic [31:0]                 cfg_wdata,
  input  logic [CW-1:0]               cfg_cpu,
  input  logic [NSHARED-1:0]          shared_in,
  output logic [NCPU*NSHARED-1:0]     shared_cpu,
  output logic [NCPU*NUM_SOFT-1:0]    soft_set
);
  localparam logic [ID_W-1:0] LO = ID_W'(SHARED_BASE);
  localparam logic [ID_W-1:0] HI = ID_W'(SHARED_BASE + NSHARED);

  logic [NCPU-1:0] route_q [NSHARED];
  logic [NCPU-1:0] route_d [NSHARED];
  logic [ID_W-1:0] wid, off;
  logic            route_hit, soft_hit;
  logic [NCPU-1:0] self_m, tgt;
  soft_mode_e      mode;

  assign wid       = cfg_wdata[ID_W-1:0];
  assign off       = wid - LO;
  assign route_hit = cfg_we && (cfg_addr == REG_ROUTE) && (wid >= LO) && (wid < HI);
  assign soft_hit  = cfg_we && (cfg_addr == REG_SOFT);
  assign mode      = soft_mode_e'(cfg_wdata[17:16]);
  assign self_m    = NCPU'(1) << cfg_cpu;

  always_comb begin
    route_d = route_q;
    if (route_hit) route_d[off[SW-1:0]] = cfg_wdata[16 +: NCPU];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSHARED; s++) route_q[s] <= '0;
    end else if (route_hit) begin
      route_q <= route_d;
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    for (genvar s = 0; s < NSHARED; s++) begin : g_line
      assign shared_cpu[c*NSHARED+s] = shared_in[s] & route_q[s][c];
    end
  end

  always_comb begin
    case (mode)
      SOFT_LIST:   tgt = cfg_wdata[24 +: NCPU];
      SOFT_OTHERS: tgt = ~self_m;
      SOFT_SELF:   tgt = self_m;
      default:     tgt = '0;
    endcase
    soft_set = '0;
    if (soft_hit) begin
      for (int c = 0; c < NCPU; c++)
        if (tgt[c]) soft_set[c*NUM_SOFT + int'(cfg_wdata[3:0])] = 1'b1;
    end
  end

  // R6: a self-targeted write raises exactly one pending bit
  a_r6_self_single: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_hit && cfg_wdata[17:16] == 2'd2) |-> $countones(soft_set) == 1);
  // R6: an all-but-self write reaches every other CPU
  a_r6_others_count: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_hit && cfg_wdata[17:16] == 2'd1) |-> $countones(soft_set) == NCPU - 1);
  // R6: mode 3 reaches nobody
  a_r6_none_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_hit && cfg_wdata[17:16] == 2'd3) |-> soft_set == '0);
endmodule

// File: rtl/midist_cpu.sv
module midist_cpu
  import midist_pkg::*;
#(
  parameter int NSHARED = 8,
  localparam int NID    = SHARED_BASE + NSHARED,
  localparam int IW     = $clog2(NID)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_addr,
  input  logic [31:0]          cfg_wdata,
  input  logic [NUM_SOFT-1:0]  soft_set,
  input  logic                 timer_irq,
  input  logic                 wdog_irq,
  input  logic [NSHARED-1:0]   shared_lines,
  input  logic                 ack,
  input  logic                 eoi,
  input  logic [ID_W-1:0]      eoi_id,
  output logic                 irq_req,
  output logic [ID_W-1:0]      ack_id
);
  logic [NID-1:0]      en_q, en_d, act_q, act_d, line, cand;
  logic [NUM_SOFT-1:0] soft_q, soft_d;
  logic [PRIO_W-1:0]   prio_q [NID];
  logic [PRIO_W-1:0]   prio_d [NID];
  logic [ID_W-1:0]     ack_id_q, ack_id_d;
  logic [PRIO_W:0]     run_prio, best_prio;
  logic [IW-1:0]       best_id, widx, eidx;
  logic                found, wid_ok, eoi_ok;

  assign widx   = cfg_wdata[IW-1:0];
  assign wid_ok = cfg_wdata[ID_W-1:0] < ID_W'(NID);
  assign eidx   = eoi_id[IW-1:0];
  assign eoi_ok = eoi && (eoi_id < ID_W'(NID));

  always_comb begin
    line = '0;
    line[NUM_SOFT-1:0]           = soft_q;
    line[ID_TIMER]               = timer_irq;
    line[ID_WDOG]                = wdog_irq;
    line[NID-1:SHARED_BASE]      = shared_lines;
  end
  assign cand = line & ~act_q & en_q;

  // running priority: most urgent taken interrupt, 16 when idle
  always_comb begin
    run_prio = 5'd16;
    for (int i = 0; i < NID; i++)
      if (act_q[i] && ({1'b0, prio_q[i]} < run_prio)) run_prio = {1'b0, prio_q[i]};
  end

  // winner: strictly beats running priority; ascending scan keeps lower ID on ties
  always_comb begin
    best_prio = run_prio;
    best_id   = '0;
    found     = 1'b0;
    for (int i = 0; i < NID; i++) begin
      if (cand[i] && ({1'b0, prio_q[i]} < best_prio)) begin
        best_prio = {1'b0, prio_q[i]};
        best_id   = IW'(i);
        found     = 1'b1;
      end
    end
  end
  assign irq_req = found;
  assign ack_id  = ack_id_q;

  always_comb begin
    act_d    = act_q;
    soft_d   = soft_q;
    ack_id_d = ack_id_q;
    en_d     = en_q;
    prio_d   = prio_q;
    if (eoi_ok) act_d[eidx] = 1'b0;
    if (ack) begin
      if (found) begin
        act_d[best_id] = 1'b1;
        ack_id_d       = ID_W'(best_id);
        if (best_id < IW'(NUM_SOFT)) soft_d[best_id[3:0]] = 1'b0;
      end else begin
        ack_id_d = ID_NONE;
      end
    end
    soft_d = soft_d | soft_set;
    if (cfg_we && wid_ok) begin
      case (cfg_addr)
        REG_ENABLE: en_d[widx]   = cfg_wdata[16];
        REG_PRIO:   prio_d[widx] = cfg_wdata[19:16];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= '0;
      soft_q   <= '0;
      en_q     <= '0;
      ack_id_q <= ID_NONE;
      for (int i = 0; i < NID; i++) prio_q[i] <= '0;
    end else begin
      act_q  <= act_d;
      soft_q <= soft_d;
      if (ack) ack_id_q <= ack_id_d;
      if (cfg_we) begin
        en_q   <= en_d;
        prio_q <= prio_d;
      end
    end
  end

  // R8: nothing qualifying gives the spurious ID
  a_r8_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_req) |=> ack_id == ID_NONE);
  // R8: a granted ID is reported and becomes taken
  a_r8_grant_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req) |=> (act_q[$past(best_id)] && ack_id == ID_W'($past(best_id))));
  // R9: each grant makes the running priority strictly more urgent
  a_r9_preempt_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && !cfg_we) |=> run_prio < $past(run_prio));
  // R10: end of interrupt releases the ID
  a_r10_eoi_release: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_ok && !(ack && irq_req)) |=> !act_q[$past(eidx)]);
endmodule

// File: rtl/midist_top.sv
module midist_top
  import midist_pkg::*;
#(
  parameter int NCPU    = 4,
  parameter int NSHARED = 8,
  localparam int CW     = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [CW-1:0]          cfg_cpu,
  input  logic [1:0]             cfg_addr,
  input  logic [31:0]            cfg_wdata,
  input  logic [NSHARED-1:0]     shared_in,
  input  logic [NCPU-1:0]        timer_irq,
  input  logic [NCPU-1:0]        wdog_irq,
  input  logic [NCPU-1:0]        fiq_in,
  input  logic [NCPU-1:0]        cpu_ack,
  input  logic [NCPU-1:0]        cpu_eoi,
  input  logic [NCPU*ID_W-1:0]   cpu_eoi_id,
  output logic [NCPU-1:0]        cpu_irq,
  output logic [NCPU*ID_W-1:0]   cpu_ack_id,
  output logic [NCPU-1:0]        fiq_out
);
  logic [1:0]                 rst_sync;
  logic                       rst_int_n;
  logic [NCPU*NSHARED-1:0]    shared_cpu;
  logic [NCPU*NUM_SOFT-1:0]   soft_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign fiq_out = fiq_in;

  midist_route #(.NCPU(NCPU), .NSHARED(NSHARED)) u_route (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_cpu    (cfg_cpu),
    .shared_in  (shared_in),
    .shared_cpu (shared_cpu),
    .soft_set   (soft_set)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    midist_cpu #(.NSHARED(NSHARED)) u_cpu (
      .clk          (clk),
      .rst_n        (rst_int_n),
      .cfg_we       (cfg_we && (cfg_cpu == CW'(c))),
      .cfg_addr     (cfg_addr),
      .cfg_wdata    (cfg_wdata),
      .soft_set     (soft_set[c*NUM_SOFT +: NUM_SOFT]),
      .timer_irq    (timer_irq[c]),
      .wdog_irq     (wdog_irq[c]),
      .shared_lines (shared_cpu[c*NSHARED +: NSHARED]),
      .ack          (cpu_ack[c]),
      .eoi          (cpu_eoi[c]),
      .eoi_id       (cpu_eoi_id[c*ID_W +: ID_W]),
      .irq_req      (cpu_irq[c]),
      .ack_id       (cpu_ack_id[c*ID_W +: ID_W])
    );
  end

  // R11: fast-interrupt pass-through tracks its input
  a_r11_fiq_pass: assert property (@(posedge clk) disable iff (!rst_int_n)
    fiq_out == fiq_in);
endmodule

// File: tb/tb_midist_top.sv
module tb_midist_top;
  localparam int NCPU = 4;
  localparam int NSH  = 8;
  localparam int NID  = 32 + NSH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_cpu = '0;
  logic [1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [NSH-1:0] shared_in = '0;
  logic [NCPU-1:0] timer_irq = '0, wdog_irq = '0, fiq_in = '0;
  logic [NCPU-1:0] cpu_ack = '0, cpu_eoi = '0;
  logic [NCPU*10-1:0] cpu_eoi_id = '0;
  logic [NCPU-1:0] cpu_irq, fiq_out;
  logic [NCPU*10-1:0] cpu_ack_id;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 1'b0;

  int m_en [NCPU][NID];
  int m_pr [NCPU][NID];
  int m_act [NCPU][NID];
  int m_sgi [NCPU][16];
  int m_rt [NSH][NCPU];
  int m_ack [NCPU];

  always #4 clk = ~clk;

  midist_top #(.NCPU(NCPU), .NSHARED(NSH)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cpu(cfg_cpu), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .shared_in(shared_in), .timer_irq(timer_irq), .wdog_irq(wdog_irq),
    .fiq_in(fiq_in), .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi), .cpu_eoi_id(cpu_eoi_id),
    .cpu_irq(cpu_irq), .cpu_ack_id(cpu_ack_id), .fiq_out(fiq_out));

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int m_line(int c, int id);
    if (id < 16) return m_sgi[c][id];
    if (id == 29) return int'(timer_irq[c]);
    if (id == 30) return int'(wdog_irq[c]);
    if (id >= 32) return (shared_in[id-32] && m_rt[id-32][c] != 0) ? 1 : 0;
    return 0;
  endfunction

  function automatic int m_best(int c);
    int rp = 16;
    int b = -1;
    for (int id = 0; id < NID; id++) if (m_act[c][id] != 0 && m_pr[c][id] < rp) rp = m_pr[c][id];
    for (int id = 0; id < NID; id++)
      if (m_line(c, id) != 0 && m_act[c][id] == 0 && m_en[c][id] != 0 && m_pr[c][id] < rp) begin
        rp = m_pr[c][id];
        b = id;
      end
    return b;
  endfunction

  always @(posedge clk) begin : model
    int b [NCPU];
    int id, md, sid;
    if (!rst_n) begin
      for (int c = 0; c < NCPU; c++) begin
        m_ack[c] = 1023;
        for (int i = 0; i < NID; i++) begin m_en[c][i] = 0; m_pr[c][i] = 0; m_act[c][i] = 0; end
        for (int i = 0; i < 16; i++) m_sgi[c][i] = 0;
        for (int s = 0; s < NSH; s++) m_rt[s][c] = 0;
      end
    end else begin
      for (int c = 0; c < NCPU; c++) b[c] = m_best(c);
      for (int c = 0; c < NCPU; c++) begin
        id = int'(cpu_eoi_id[c*10 +: 10]);
        if (cpu_eoi[c] && id < NID) m_act[c][id] = 0;
        if (cpu_ack[c]) begin
          if (b[c] >= 0) begin
            m_act[c][b[c]] = 1;
            if (b[c] < 16) m_sgi[c][b[c]] = 0;
            m_ack[c] = b[c];
          end else m_ack[c] = 1023;
        end
      end
      if (cfg_we) begin
        id = int'(cfg_wdata[9:0]);
        case (cfg_addr)
          2'd0: if (id < NID) m_en[cfg_cpu][id] = int'(cfg_wdata[16]);
          2'd1: if (id < NID) m_pr[cfg_cpu][id] = int'(cfg_wdata[19:16]);
          2'd2: if (id >= 32 && id < NID)
                  for (int c = 0; c < NCPU; c++) m_rt[id-32][c] = int'(cfg_wdata[16+c]);
          default: begin
            md = int'(cfg_wdata[17:16]);
            sid = int'(cfg_wdata[3:0]);
            for (int c = 0; c < NCPU; c++)
              if ((md == 0 && cfg_wdata[24+c]) || (md == 1 && c != int'(cfg_cpu)) ||
                  (md == 2 && c == int'(cfg_cpu))) m_sgi[c][sid] = 1;
          end
        endcase
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (cmp_on) begin
      for (int c = 0; c < NCPU; c++) begin
        chk(int'(cpu_irq[c]), (m_best(c) >= 0) ? 1 : 0, $sformatf("R7 model cpu_irq[%0d]", c));
        chk(int'(cpu_ack_id[c*10 +: 10]), m_ack[c], $sformatf("R8 model ack_id[%0d]", c));
      end
    end
  end

  task automatic wr(input int cpu, input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_cpu = 2'(cpu); cfg_addr = 2'(addr); cfg_wdata = 32'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_ack(input int c, output int id);
    @(negedge clk);
    cpu_ack[c] = 1'b1;
    @(negedge clk);
    cpu_ack[c] = 1'b0;
    id = int'(cpu_ack_id[c*10 +: 10]);
  endtask

  task automatic do_eoi(input int c, input int id);
    @(negedge clk);
    cpu_eoi[c] = 1'b1; cpu_eoi_id[c*10 +: 10] = 10'(id);
    @(negedge clk);
    cpu_eoi[c] = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;
    for (int c = 0; c < NCPU; c++) begin
      chk(int'(cpu_irq[c]), 0, "R1 irq after reset");
      chk(int'(cpu_ack_id[c*10 +: 10]), 1023, "R1 ack_id after reset");
    end
    do_ack(0, v); chk(v, 1023, "R8 spurious ack");
    timer_irq[0] = 1'b1; @(negedge clk);
    chk(int'(cpu_irq[0]), 0, "R3 disabled timer ignored");
    timer_irq[0] = 1'b0;

    for (int c = 0; c < NCPU; c++)
      for (int id = 0; id < NID; id++)
        if (id < 16 || id == 29 || id == 30 || id >= 32) wr(c, 0, (1 << 16) | id);
    wr(1, 1, (9 << 16) | 5);  wr(2, 1, (2 << 16) | 5);  wr(3, 1, (2 << 16) | 5);
    wr(2, 1, (2 << 16) | 30); wr(1, 1, (12 << 16) | 29); wr(1, 1, (9 << 16) | 7);

    // routing to one CPU, shared ID base
    wr(0, 2, (4'b0010 << 16) | 32);
    shared_in[0] = 1'b1; @(negedge clk);
    chk(int'(cpu_irq[1]), 1, "R5 routed cpu sees line");
    chk(int'(cpu_irq[0]), 0, "R5 unrouted cpu blind");
    do_ack(1, v); chk(v, 32, "R2 shared line 0 is ID 32");
    chk(int'(cpu_irq[1]), 0, "R8 taken no longer requests");
    do_eoi(1, 32);
    chk(int'(cpu_irq[1]), 1, "R10 level still high re-pends");
    shared_in[0] = 1'b0; @(negedge clk);
    chk(int'(cpu_irq[1]), 0, "R10 level dropped");

    // software interrupt to all but the sender, priority per receiver
    wr(0, 3, (1 << 16) | 5);
    chk(int'(cpu_irq[0]), 0, "R6 sender excluded");
    chk(int'(cpu_irq[3]), 1, "R6 others targeted");
    wdog_irq[2] = 1'b1;
    do_ack(2, v); chk(v, 5, "R4 tie goes to lower ID");
    do_ack(2, v); chk(v, 1023, "R9 equal priority does not preempt");
    do_eoi(2, 5);
    do_ack(2, v); chk(v, 30, "R2 watchdog is ID 30");
    do_eoi(2, 30); wdog_irq[2] = 1'b0;

    timer_irq[1] = 1'b1;
    do_ack(1, v); chk(v, 5, "R4 receiver priority 9 beats 12");
    chk(int'(cpu_irq[1]), 0, "R9 less urgent held off");
    wr(1, 1, (3 << 16) | 29);
    chk(int'(cpu_irq[1]), 1, "R9 more urgent preempts");
    do_ack(1, v); chk(v, 29, "R2 timer is ID 29");
    do_eoi(1, 29); timer_irq[1] = 1'b0;
    wr(0, 3, (0 << 16) | (4'b0010 << 24) | 7);
    chk(int'(cpu_irq[1]), 0, "R10 restored priority 9 blocks equal");
    do_eoi(1, 5);
    chk(int'(cpu_irq[1]), 1, "R10 idle cpu takes pending");
    do_ack(1, v); chk(v, 7, "R6 list target");
    do_eoi(1, 7);
    do_ack(3, v); chk(v, 5, "R4 cpu3 gets SGI 5");
    do_eoi(3, 5);

    // self and list modes, silent mode
    wr(2, 3, (2 << 16) | 9);
    chk(int'(cpu_irq[2]), 1, "R6 self targeted");
    chk(int'(cpu_irq[1]), 0, "R6 self excludes others");
    do_ack(2, v); chk(v, 9, "R6 self ID"); do_eoi(2, 9);
    wr(0, 3, (4'b1001 << 24) | 11);
    chk(int'(cpu_irq[0]), 1, "R6 list cpu0");
    chk(int'(cpu_irq[2]), 0, "R6 list omits cpu2");
    do_ack(0, v); chk(v, 11, "R6 list ID"); do_eoi(0, 11);
    do_ack(3, v); chk(v, 11, "R6 list ID cpu3"); do_eoi(3, 11);
    wr(0, 3, (3 << 16) | 12);
    chk(int'(cpu_irq), 0, "R6 mode 3 reaches nobody");

    // per-CPU disable, route to all
    wr(0, 2, (4'b1111 << 16) | 33);
    wr(0, 0, 33);
    shared_in[1] = 1'b1; @(negedge clk);
    chk(int'(cpu_irq[0]), 0, "R3 disabled on cpu0");
    chk(int'(cpu_irq[2]), 1, "R5 all routed");
    do_ack(0, v); chk(v, 1023, "R3 disabled not granted");
    for (int c = 1; c < NCPU; c++) begin
      do_ack(c, v); chk(v, 33, "R5 shared ID 33");
    end
    do_eoi(3, 1000);
    chk(int'(cpu_irq[3]), 0, "R10 out of range eoi ignored");
    shared_in[1] = 1'b0;
    for (int c = 1; c < NCPU; c++) do_eoi(c, 33);

    fiq_in = 4'b0101; #1;
    chk(int'(fiq_out), 5, "R11 fiq pass-through");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule